// File: doc/BRIEF.md
# Delta-Sigma Loop Overload Recovery Controller

This controller sits next to the flash quantizer of a multibit delta-sigma modulator. It runs on the sampling clock. It takes the eight-bit thermometer word of a nine-level quantizer and two extra comparator flags, one above the top of the range and one below the bottom. Either flag means the quantizer input has left its allowed range by at least one LSB. That counts as an overload, a sign that the loop may be going unstable.

An overload drives the loop into a forced stop. The loop-reset output stays high and the modulator enable stays low for a fixed number of sampling periods, 1024 by default. The controller then releases the loop into a short trial run, 64 periods by default. Any overload during the trial starts a new stop interval of full length. A trial with no overload moves the controller into normal running, where an overload again starts the stop interval. A sticky flag records that an overload was seen, and only an explicit clear input resets it. A registered level output reports how many thermometer bits are set.

Top module: `ovl_recovery_ctrl`

## Requirements
- R1: While the active-low asynchronous reset is applied, loopReset is 1, modEnable is 0, trialMode is 0, ovlSeen is 0 and sampleLevel is 0. The controller leaves reset in the stop state with its interval counter at zero.
- R2: An overload is overHi = 1 or overLo = 1 on a clock edge. The thermometer word alone, including all ones or all zeros, never causes an overload.
- R3: The stop interval lasts exactly RST_CYCLES clock edges (default 1024). During it loopReset = 1 and modEnable = 0. On the edge that ends it, loopReset falls and modEnable and trialMode rise.
- R4: A trial run with no overload lasts exactly TRIAL_CYCLES edges (default 64). During it modEnable = 1, trialMode = 1 and loopReset = 0. After it trialMode = 0 and modEnable stays 1, which is normal running.
- R5: An overload on any edge of a trial run, the last one included, sets loopReset = 1 after that edge. The stop interval that follows has its full length.
- R6: An overload on an edge in normal running sets loopReset = 1 after that edge.
- R7: Overload flags seen during the stop interval neither lengthen nor restart it, and they do not set ovlSeen.
- R8: ovlSeen becomes 1 on the edge after an overload seen outside the stop interval. It stays 1 until an edge with ovlClr = 1 and no such overload. If set and clear arrive on the same edge, the set wins.
- R9: sampleLevel equals the number of ones in thermCode, one edge later. This holds for every value of thermCode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| thermCode | input | LEVELS-1 | Quantizer thermometer word |
| overHi | input | 1 | Comparator flag above the top of the range |
| overLo | input | 1 | Comparator flag below the bottom of the range |
| ovlClr | input | 1 | Clears the sticky overload flag |
| loopReset | output | 1 | Holds the loop filter in reset |
| modEnable | output | 1 | Lets the modulator run |
| trialMode | output | 1 | High during the trial run |
| ovlSeen | output | 1 | Sticky flag: an overload has occurred |
| sampleLevel | output | $clog2(LEVELS) | Registered count of set thermometer bits |

## Verification
The bench uses short intervals and counts the edges of every stop interval and every trial run. That separates an off-by-one exit from a correct one.

Overloads are placed at several points:
- in the middle of a trial run and on its last edge, which shows whether the overload wins over the trial exit;
- in normal running;
- inside a stop interval, which shows whether a stray flag restarts the interval or sets the sticky flag.

Each flag is used on its own, so a missing term in the overload decode is caught. A clear that lands on the same edge as an overload tests the set-over-clear priority. All 256 thermometer words are swept with no overload flags, which checks the level count and shows that the code alone never stops the loop.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_TRIAL = 2'd1,
    ST_RUN   = 2'd2
  } ovlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stopClr;
    logic stopInc;
    logic trialClr;
    logic trialInc;
    logic stickyArm;
  } ovlStrobe_t;
endpackage

// File: rtl/ovl_datapath.sv
`timescale 1ns/1ps
module ovl_datapath
  import ovl_pkg::*;
#(
  parameter int LEVELS       = 9,
  parameter int RST_CYCLES   = 1024,
  parameter int TRIAL_CYCLES = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [LEVELS-2:0]          thermCode,
  input  logic                       overHi,
  input  logic                       overLo,
  input  logic                       ovlClr,
  input  ovlStrobe_t                 strobe,
  output logic                       overload,
  output logic                       stopDone,
  output logic                       trialDone,
  output logic                       ovlSeen,
  output logic [$clog2(LEVELS)-1:0]  sampleLevel
);
  localparam int THERM_W = LEVELS - 1;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int STOP_W  = $clog2(RST_CYCLES) + 1;
  localparam int TRIAL_W = $clog2(TRIAL_CYCLES) + 1;
  localparam logic [STOP_W-1:0]  STOP_LAST  = STOP_W'(RST_CYCLES - 1);
  localparam logic [TRIAL_W-1:0] TRIAL_LAST = TRIAL_W'(TRIAL_CYCLES - 1);

  logic [STOP_W-1:0]  stopCnt;
  logic [TRIAL_W-1:0] trialCnt;
  logic [LVL_W-1:0]   onesCount;

  assign overload  = overHi | overLo;
  assign stopDone  = (stopCnt == STOP_LAST);
  assign trialDone = (trialCnt == TRIAL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopCnt <= '0;
    end else if (strobe.stopClr) begin
      stopCnt <= '0;
    end else if (strobe.stopInc) begin
      stopCnt <= stopCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCnt <= '0;
    end else if (strobe.trialClr) begin
      trialCnt <= '0;
    end else if (strobe.trialInc) begin
      trialCnt <= trialCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovlSeen <= 1'b0;
    end else if (strobe.stickyArm && overload) begin
      ovlSeen <= 1'b1;
    end else if (ovlClr) begin
      ovlSeen <= 1'b0;
    end
  end

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < THERM_W; i++) begin
      onesCount = onesCount + LVL_W'(thermCode[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleLevel <= '0;
    end else begin
      sampleLevel <= onesCount;
    end
  end
endmodule

// File: rtl/ovl_control.sv
`timescale 1ns/1ps
module ovl_control
  import ovl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       overload,
  input  logic       stopDone,
  input  logic       trialDone,
  output ovlStrobe_t strobe,
  output logic       loopReset,
  output logic       modEnable,
  output logic       trialMode
);
  ovlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_STOP;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_STOP: begin
        if (stopDone) begin
          stateNext       = ST_TRIAL;
          strobe.stopClr  = 1'b1;
          strobe.trialClr = 1'b1;
        end else begin
          strobe.stopInc = 1'b1;
        end
      end
      ST_TRIAL: begin
        strobe.stickyArm = 1'b1;
        if (overload) begin
          stateNext       = ST_STOP;
          strobe.stopClr  = 1'b1;
          strobe.trialClr = 1'b1;
        end else if (trialDone) begin
          stateNext       = ST_RUN;
          strobe.trialClr = 1'b1;
        end else begin
          strobe.trialInc = 1'b1;
        end
      end
      ST_RUN: begin
        strobe.stickyArm = 1'b1;
        if (overload) begin
          stateNext      = ST_STOP;
          strobe.stopClr = 1'b1;
        end
      end
      default: begin
        stateNext = ST_STOP;
      end
    endcase
  end

  assign loopReset = (state == ST_STOP);
  assign modEnable = (state != ST_STOP);
  assign trialMode = (state == ST_TRIAL);
endmodule

// File: rtl/ovl_recovery_ctrl.sv
`timescale 1ns/1ps
module ovl_recovery_ctrl
  import ovl_pkg::*;
#(
  parameter int LEVELS       = 9,
  parameter int RST_CYCLES   = 1024,
  parameter int TRIAL_CYCLES = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LEVELS-2:0]         thermCode,
  input  logic                      overHi,
  input  logic                      overLo,
  input  logic                      ovlClr,
  output logic                      loopReset,
  output logic                      modEnable,
  output logic                      trialMode,
  output logic                      ovlSeen,
  output logic [$clog2(LEVELS)-1:0] sampleLevel
);
  ovlStrobe_t strobe;
  logic       overload;
  logic       stopDone;
  logic       trialDone;

  ovl_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .overload  (overload),
    .stopDone  (stopDone),
    .trialDone (trialDone),
    .strobe    (strobe),
    .loopReset (loopReset),
    .modEnable (modEnable),
    .trialMode (trialMode)
  );

  ovl_datapath #(
    .LEVELS       (LEVELS),
    .RST_CYCLES   (RST_CYCLES),
    .TRIAL_CYCLES (TRIAL_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .thermCode   (thermCode),
    .overHi      (overHi),
    .overLo      (overLo),
    .ovlClr      (ovlClr),
    .strobe      (strobe),
    .overload    (overload),
    .stopDone    (stopDone),
    .trialDone   (trialDone),
    .ovlSeen     (ovlSeen),
    .sampleLevel (sampleLevel)
  );
endmodule

// File: rtl/ovl_recovery_chk.sv
`timescale 1ns/1ps
module ovl_recovery_chk #(
  parameter int LEVELS       = 9,
  parameter int RST_CYCLES   = 1024,
  parameter int TRIAL_CYCLES = 64
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [LEVELS-2:0]         thermCode,
  input logic                      overHi,
  input logic                      overLo,
  input logic                      ovlClr,
  input logic                      loopReset,
  input logic                      modEnable,
  input logic                      trialMode,
  input logic                      ovlSeen,
  input logic [$clog2(LEVELS)-1:0] sampleLevel
);
  int unsigned stopRun;
  int unsigned trialRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopRun  <= 0;
      trialRun <= 0;
    end else begin
      stopRun  <= loopReset ? stopRun + 1 : 0;
      trialRun <= trialMode ? trialRun + 1 : 0;
    end
  end

  // R3: stop interval has exact length
  a_r3_stop_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loopReset) |-> (stopRun == RST_CYCLES));

  // R4: a clean trial run has exact length before normal running
  a_r4_trial_length: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(trialMode) && modEnable) |-> (trialRun == TRIAL_CYCLES));

  // R5: overload in trial stops the loop
  a_r5_trial_overload: assert property (@(posedge clk) disable iff (!rstN)
    (trialMode && (overHi || overLo)) |=> loopReset);

  // R6: overload in normal running stops the loop
  a_r6_run_overload: assert property (@(posedge clk) disable iff (!rstN)
    (modEnable && !trialMode && (overHi || overLo)) |=> loopReset);

  // R8: sticky flag set and hold
  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rstN)
    (modEnable && (overHi || overLo)) |=> ovlSeen);

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ovlSeen && !ovlClr) |=> ovlSeen);

  // R9: level count
  a_r9_level: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (32'(sampleLevel) == $countones($past(thermCode))));
endmodule

bind ovl_recovery_ctrl ovl_recovery_chk #(
  .LEVELS       (LEVELS),
  .RST_CYCLES   (RST_CYCLES),
  .TRIAL_CYCLES (TRIAL_CYCLES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .thermCode   (thermCode),
  .overHi      (overHi),
  .overLo      (overLo),
  .ovlClr      (ovlClr),
  .loopReset   (loopReset),
  .modEnable   (modEnable),
  .trialMode   (trialMode),
  .ovlSeen     (ovlSeen),
  .sampleLevel (sampleLevel)
);

// File: tb/ovl_recovery_ctrl_tb.sv
`timescale 1ns/1ps
module ovl_recovery_ctrl_tb;
  localparam int LEVELS = 9;
  localparam int RST    = 20;
  localparam int TRIAL  = 6;
  localparam int LVL_W  = $clog2(LEVELS);

  logic             clk = 1'b0;
  logic             rstN;
  logic [LEVELS-2:0] thermCode;
  logic             overHi, overLo, ovlClr;
  logic             loopReset, modEnable, trialMode, ovlSeen;
  logic [LVL_W-1:0] sampleLevel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ovl_recovery_ctrl #(
    .LEVELS       (LEVELS),
    .RST_CYCLES   (RST),
    .TRIAL_CYCLES (TRIAL)
  ) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .thermCode   (thermCode),
    .overHi      (overHi),
    .overLo      (overLo),
    .ovlClr      (ovlClr),
    .loopReset   (loopReset),
    .modEnable   (modEnable),
    .trialMode   (trialMode),
    .ovlSeen     (ovlSeen),
    .sampleLevel (sampleLevel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // stop interval entered; 'already' edges elapsed since entry
  task automatic finish_stop(input int already);
    for (int e = already + 1; e < RST; e++) begin
      step();
      chk("R3 loopReset held", int'(loopReset), 1);
    end
    step();
    chk("R3 loopReset released", int'(loopReset), 0);
    chk("R3 trial entered", int'(trialMode), 1);
    chk("R4 enable in trial", int'(modEnable), 1);
  endtask

  task automatic finish_trial();
    for (int e = 1; e < TRIAL; e++) begin
      step();
      chk("R4 trial held", int'(trialMode), 1);
    end
    step();
    chk("R4 trial ended", int'(trialMode), 0);
    chk("R4 normal enable", int'(modEnable), 1);
    chk("R4 no reset", int'(loopReset), 0);
  endtask

  initial begin
    rstN = 1'b0; thermCode = '1; overHi = 1'b0; overLo = 1'b0; ovlClr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 loopReset", int'(loopReset), 1);
    chk("R1 modEnable", int'(modEnable), 0);
    chk("R1 trialMode", int'(trialMode), 0);
    chk("R1 ovlSeen", int'(ovlSeen), 0);
    chk("R1 sampleLevel", int'(sampleLevel), 0);
    thermCode = '0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    finish_stop(0);
    finish_trial();

    // R6 with overLo in normal running; R2 low flag
    overLo = 1'b1;
    step();
    overLo = 1'b0;
    chk("R6 overload in run", int'(loopReset), 1);
    chk("R6 enable dropped", int'(modEnable), 0);
    chk("R8 sticky set", int'(ovlSeen), 1);
    ovlClr = 1'b1;
    step();
    ovlClr = 1'b0;
    chk("R8 sticky cleared", int'(ovlSeen), 0);

    // R7: flags inside the stop interval
    overHi = 1'b1;
    repeat (3) step();
    overHi = 1'b0;
    chk("R7 sticky untouched", int'(ovlSeen), 0);
    chk("R7 still stopped", int'(loopReset), 1);
    finish_stop(4);

    // R5 mid-trial with overHi; R2 high flag
    step();
    step();
    overHi = 1'b1;
    step();
    overHi = 1'b0;
    chk("R5 mid-trial overload", int'(loopReset), 1);
    chk("R5 trial left", int'(trialMode), 0);
    chk("R8 sticky from overHi", int'(ovlSeen), 1);
    ovlClr = 1'b1;
    step();
    ovlClr = 1'b0;
    chk("R8 clear after overHi", int'(ovlSeen), 0);
    finish_stop(1);

    // R5 last trial edge, with a simultaneous clear (R8 set wins)
    for (int e = 1; e < TRIAL; e++) step();
    chk("R5 still in trial", int'(trialMode), 1);
    overLo = 1'b1;
    ovlClr = 1'b1;
    step();
    overLo = 1'b0;
    ovlClr = 1'b0;
    chk("R5 last-edge overload", int'(loopReset), 1);
    chk("R5 not normal", int'(modEnable), 0);
    chk("R8 set beats clear", int'(ovlSeen), 1);
    step();
    chk("R8 sticky holds", int'(ovlSeen), 1);
    finish_stop(1);
    finish_trial();

    // R9 and R2: sweep every thermometer word, no flags
    for (int v = 0; v < (1 << (LEVELS - 1)); v++) begin
      thermCode = (LEVELS-1)'(v);
      step();
      chk("R9 level count", int'(sampleLevel), $countones(v));
      chk("R2 code alone no overload", int'(loopReset), 0);
    end
    chk("R2 sticky untouched by code", int'(ovlSeen), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule